// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the order of column addresses for one SDRAM read or write burst. A controller pulses a start strobe. With that strobe it gives an 8-bit start column, a 3-bit burst length code and a burst type bit, which selects sequential or interleaved order. From the next cycle on, the block gives one column address per clock, with a valid flag. A last flag marks the beat that ends the burst. Fixed-length bursts stay inside an aligned block of columns whose size equals the burst length. When the address reaches the end of that block, it wraps to the start of the same block. Full-page bursts walk the whole 256-column page. A full-page burst wraps past the top of the page and keeps running until a terminate strobe arrives.

The core is a three-state machine:

- `ST_IDLE`: no burst is running.
- `ST_FIXED`: a burst of 1, 2, 4 or 8 beats is running.
- `ST_PAGE`: a full-page burst is running.

The transitions are:

- `start`: from any state. It goes to `ST_FIXED`, or to `ST_PAGE` when the decoded length is full page.
- `fixed_done`: from `ST_FIXED` to `ST_IDLE`, on the last beat when no start strobe is present.
- `page_stop`: from `ST_PAGE` to `ST_IDLE`, on a terminate strobe when no start strobe is present.
- `hold`: every other case. The machine stays in its state and steps the beat counter.

A start strobe always wins, so the column can be changed on any cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o and last_o are low and no address is produced until a start strobe.
- R2: Length codes map as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 with sequential type gives full page. Beat 0 appears in the cycle after the clock edge that samples start_i, and one beat follows per cycle.
- R3: During a fixed burst of length L = 2^n, col_o bits [7:n] stay equal to those of the start column, so the address wraps inside its aligned block.
- R4: In sequential order (interleave_i = 0), beat k has low offset (s + k) mod L, where s is the start column's low n bits.
- R5: In interleaved order (interleave_i = 1), beat k has low offset s XOR k.
- R6: In a fixed burst, last_o is high only on beat L-1. If no new start arrives, valid_o is low in the following cycle.
- R7: In full-page mode, beat k is (start + k) mod 256 and the burst keeps running past 256 beats. last_o is high in the same cycle that term_i is high, and valid_o is low in the next cycle.
- R8: The reserved codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with interleaved type, each produce a single beat at the start column, with last_o high.
- R9: A start strobe during an active burst restarts the sequence from the new column in the next cycle. It takes priority over term_i.
- R10: term_i has no effect during a fixed-length burst or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts (or restarts) a burst with the fields below |
| start_col_i | input | 8 | Start column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| term_i | input | 1 | Ends a running full-page burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The first beat is due one cycle after the start strobe is sampled, and each later beat follows one cycle after the one before it. The bench drives inputs on the falling edge. It compares beat k at the falling edge k+1 cycles after the start, then checks that valid_o has dropped exactly one cycle after the expected last beat. The full-page last_o follows term_i without a register in between. So the bench raises term_i, waits a short settling delay, checks last_o in that same cycle, and then checks at the next falling edge that the burst has ended.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } burst_state_e;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] LEN_ONE   = 3'b000;
    localparam logic [CODE_W-1:0] LEN_TWO   = 3'b001;
    localparam logic [CODE_W-1:0] LEN_FOUR  = 3'b010;
    localparam logic [CODE_W-1:0] LEN_EIGHT = 3'b011;
    localparam logic [CODE_W-1:0] LEN_PAGE  = 3'b111;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              interleave_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o
);

    localparam int LG_W = $clog2(COL_W + 1);

    logic [LG_W-1:0] lg;

    always_comb begin
        lg     = '0;
        page_o = 1'b0;
        unique case (code_i)
            LEN_ONE:   lg = LG_W'(0);
            LEN_TWO:   lg = LG_W'(1);
            LEN_FOUR:  lg = LG_W'(2);
            LEN_EIGHT: lg = LG_W'(3);
            LEN_PAGE: begin
                if (!interleave_i) begin
                    lg     = LG_W'(COL_W);
                    page_o = 1'b1;
                end
            end
            default:   lg = LG_W'(0);
        endcase
    end

    always_comb begin
        if (page_o) begin
            mask_o = '1;
        end else begin
            mask_o = (COL_W'(1) << lg) - COL_W'(1);
        end
    end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (step_i) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_addr_order.sv
module burst_addr_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             interleave_i,
    input  logic [COL_W-1:0] count_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] ilv_off;
    logic [COL_W-1:0] low_off;

    always_comb begin
        seq_off = (base_col_i + count_i) & mask_i;
        ilv_off = (base_col_i ^ count_i) & mask_i;
        low_off = interleave_i ? ilv_off : seq_off;
        col_o   = (base_col_i & ~mask_i) | low_off;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] len_code_i,
    input  logic              interleave_i,
    input  logic              term_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);

    burst_state_e     state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic [COL_W-1:0] new_mask;
    logic             new_page;
    logic [COL_W-1:0] beat_cnt;
    logic             running;
    logic             fixed_end;

    burst_len_decode #(.COL_W(COL_W)) i_decode (
        .code_i       (len_code_i),
        .interleave_i (interleave_i),
        .mask_o       (new_mask),
        .page_o       (new_page)
    );

    assign running = (state_q != ST_IDLE);

    burst_beat_counter #(.CNT_W(COL_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (running),
        .count_o (beat_cnt)
    );

    burst_addr_order #(.COL_W(COL_W)) i_order (
        .base_col_i   (base_q),
        .mask_i       (mask_q),
        .interleave_i (ilv_q),
        .count_i      (beat_cnt),
        .col_o        (col_o)
    );

    // State register and per-burst settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q <= start_col_i;
                mask_q <= new_mask;
                ilv_q  <= interleave_i;
            end
        end
    end

    assign fixed_end = (beat_cnt == mask_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = new_page ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: state_d = fixed_end ? ST_IDLE : ST_FIXED;
                ST_PAGE:  state_d = term_i ? ST_IDLE : ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                valid_o = 1'b0;
                last_o  = 1'b0;
            end
            ST_FIXED: begin
                valid_o = 1'b1;
                last_o  = fixed_end;
            end
            ST_PAGE: begin
                valid_o = 1'b1;
                last_o  = term_i;
            end
            default: begin
                valid_o = 1'b0;
                last_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input burst_state_e     state_q,
    input logic [COL_W-1:0] mask_q
);

    // R6: a last beat is always a valid beat
    a_r6_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R6: a finished fixed burst with no restart leaves the bus idle
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && last_o && !start_i) |=> !valid_o);

    // R3: upper column bits hold across beats of a fixed burst
    a_r3_block_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && !last_o && !start_i)
            |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q)));

    // R7: full-page beats step by one modulo the page
    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !term_i && !start_i)
            |=> (valid_o && col_o == $past(col_o) + COL_W'(1)));

    // R7: terminate ends a full-page burst
    a_r7_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && term_i && !start_i) |=> !valid_o);

    // R9: a start strobe always yields a beat next cycle
    a_r9_start_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    // R10: terminate cannot end a fixed burst early
    a_r10_term_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && !last_o && !start_i) |=> valid_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .term_i  (term_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .state_q (state_q),
    .mask_q  (mask_q)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .term_i       (term_i),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_len(input logic [2:0] code, input bit ilv);
        case (code)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return ilv ? 1 : 256;
            default: return 1;
        endcase
    endfunction

    function automatic int model_col(input int s, input int len, input bit ilv, input int k);
        int off;
        int base;
        if (len == 256) return (s + k) % 256;
        off  = s % len;
        base = s - off;
        return base + (ilv ? (off ^ k) : ((off + k) % len));
    endfunction

    task automatic kick(input logic [7:0] s, input logic [2:0] code, input bit ilv);
        start_i      = 1'b1;
        start_col_i  = s;
        len_code_i   = code;
        interleave_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Fixed-length burst, compared beat by beat
    task automatic run_fixed(input string tag, input logic [7:0] s, input logic [2:0] code,
                             input bit ilv, input bit hold_term);
        int len;
        len = model_len(code, ilv);
        @(negedge clk);
        term_i = hold_term;
        kick(s, code, ilv);
        for (int k = 0; k < len; k++) begin
            chk({tag, " col"}, col_o, model_col(s, len, ilv, k));
            chk({tag, " valid"}, valid_o, 1);
            chk({tag, " last"}, last_o, (k == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk({tag, " R6 valid drops"}, valid_o, 0);
        chk({tag, " R6 last low"}, last_o, 0);
        term_i = 1'b0;
    endtask

    // Full-page burst of n beats ended by terminate
    task automatic run_page(input string tag, input logic [7:0] s, input int n);
        @(negedge clk);
        kick(s, 3'b111, 1'b0);
        for (int k = 0; k < n; k++) begin
            if (k == n - 1) term_i = 1'b1;
            #1;
            chk({tag, " col"}, col_o, (s + k) % 256);
            chk({tag, " valid"}, valid_o, 1);
            chk({tag, " last"}, last_o, (k == n - 1) ? 1 : 0);
            @(negedge clk);
            term_i = 1'b0;
        end
        chk({tag, " R7 ends"}, valid_o, 0);
    endtask

    task automatic test_reset();
        chk("R1 valid after reset", valid_o, 0);
        chk("R1 last after reset", last_o, 0);
        @(negedge clk);
        term_i = 1'b1;
        @(negedge clk);
        chk("R10 term while idle", valid_o, 0);
        term_i = 1'b0;
    endtask

    task automatic test_restart();
        @(negedge clk);
        kick(8'h30, 3'b111, 1'b0);
        chk("R9 page beat0", col_o, 8'h30);
        @(negedge clk);
        chk("R9 page beat1", col_o, 8'h31);
        start_i      = 1'b1;
        start_col_i  = 8'h43;
        len_code_i   = 3'b010;
        interleave_i = 1'b1;
        term_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        term_i  = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R9 restart col", col_o, 8'h43 - k);
            chk("R9 restart valid", valid_o, 1);
            chk("R9 restart last", last_o, (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R9 restart ends", valid_o, 0);
        // restart in the middle of a fixed burst
        kick(8'h10, 3'b011, 1'b0);
        @(negedge clk);
        chk("R9 fixed beat1", col_o, 8'h11);
        kick(8'hA6, 3'b001, 1'b0);
        chk("R9 new col", col_o, 8'hA6);
        @(negedge clk);
        chk("R9 new wrap", col_o, 8'hA7);
        chk("R9 new last", last_o, 1);
        @(negedge clk);
        chk("R9 new ends", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_fixed("R2 R4 R3 seq len8", 8'h5D, 3'b011, 1'b0, 1'b0);
        run_fixed("R2 R5 ilv len4", 8'h26, 3'b010, 1'b1, 1'b0);
        run_fixed("R2 R4 seq len2", 8'h81, 3'b001, 1'b0, 1'b0);
        run_fixed("R2 single", 8'hC3, 3'b000, 1'b0, 1'b0);
        run_fixed("R5 R3 ilv len8", 8'hFB, 3'b011, 1'b1, 1'b0);
        run_fixed("R4 seq len4", 8'h07, 3'b010, 1'b0, 1'b0);
        run_fixed("R8 code101", 8'h77, 3'b101, 1'b0, 1'b0);
        run_fixed("R8 code100", 8'h12, 3'b100, 1'b1, 1'b0);
        run_fixed("R8 code110", 8'h9E, 3'b110, 1'b0, 1'b0);
        run_fixed("R8 page ilv", 8'h55, 3'b111, 1'b1, 1'b0);
        run_fixed("R10 term in fixed", 8'h0E, 3'b010, 1'b0, 1'b1);
        run_page("R7 page wrap", 8'hFE, 5);
        run_page("R7 page long", 8'h00, 260);
        run_page("R7 page term first", 8'h40, 1);
        test_restart();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule